// File: doc/BRIEF.md
# Real-Time Clock Update Controller

This block runs the once-per-second update of a real-time clock. It holds two copies of the calendar: an internal timekeeping copy that always advances, and a user copy that software reads. A one-second tick starts each update. The update-in-progress flag `uip_o` rises at once. After a fixed number of timebase ticks, at about 244 µs resolution, the internal copy advances by one second. On the next cycle that new time is copied into the user copy, the alarm registers are compared against it, the update-ended flag is raised and `uip_o` drops.

Software can stop the user copy with a freeze bit and then write a new time. While frozen, each write to a time register lands in both copies, and internal timekeeping keeps counting. Pending update-ended, alarm and periodic flags are read from one status register, and that read clears them. The active-low interrupt output is asserted while any flag whose enable bit is set is pending.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset the user time reads 00:00:00, day-of-week 0x01, date 0x01, month 0x01, year 0x00. The status register reads 0x00, `uip_o` is 0 and `irq_no` is 1.
- R2: A `sec_tick_i` pulse sets `uip_o` on the next clock edge. The internal copy advances on the LEAD_TICKS-th `tb_tick_i` pulse after that. The user copy takes the new time one cycle later, and `uip_o` clears in that same cycle. The user copy never changes while `uip_o` is high and no transfer is being made.
- R3: While control bit 0 (freeze) is 1, updates leave the user copy unchanged and the internal copy still advances. After freeze is cleared, the next update shows the internal time, which includes every second that passed while frozen.
- R4: Register addresses: 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day-of-week, 0x4 date, 0x5 month, 0x6 year, 0x7–0x9 alarm seconds/minutes/hours, 0xA control, 0xB status, 0xC bit 0 = update in progress. A write to 0x0–0x6 while freeze is 1 updates both copies. The same write while freeze is 0 is ignored.
- R5: Time is kept in BCD. Seconds and minutes wrap from 0x59 to 0x00, hours from 0x23 to 0x00, day-of-week from 0x07 to 0x01, and month from 0x12 to 0x01 with a carry into the year. The year wraps from 0x99 to 0x00.
- R6: The date wraps to 0x01 after the last day of its month. February has 29 days when the binary value of the year is a multiple of 4, and 28 days otherwise.
- R7: The update-ended flag (status bit 4) is set by every update, including updates made while freeze is 1.
- R8: In each update, alarm bytes 0x7–0x9 are compared with the new seconds, minutes and hours. Status bit 5 is set when every byte either equals its time byte or has bits 7:6 = 11 (don't care).
- R9: Reading status (0xB) returns bit 7 = interrupt summary, bit 6 = periodic, bit 5 = alarm and bit 4 = update-ended, with bits 3:0 at 0. All flags clear in the cycle of the read. A flag event in that same cycle wins.
- R10: Control bits 1, 2 and 3 enable the update-ended, alarm and periodic flags onto the interrupt. `irq_no` is low exactly when an enabled flag is pending.
- R11: A `per_evt_i` pulse sets the periodic flag whether or not it is enabled.
- R12: `tb_tick_i` pulses that arrive while no update is in progress have no effect on time or `uip_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-second pulse that starts an update |
| tb_tick_i | input | 1 | Timebase pulse, about 244 µs period |
| per_evt_i | input | 1 | Periodic event pulse from an external divider |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `re_i` |
| uip_o | output | 1 | Update in progress |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench drives the calendar across a midnight that ends February in a non-leap year, across a leap February 28, and across a New Year's Eve in year 99. A wrong days-per-month table or a missing carry shows up as an impossible date or month. It reads seconds while `uip_o` is high, before the timebase tick arrives. A design that transfers on the second tick would return the new value there. It leaves the block frozen for one update and then checks that the next update jumps by two seconds. A design that stops the internal chain would show only one. It also checks that status reads clear the flags, that don't-care alarm bytes match, that timebase ticks outside an update are ignored, and that writes made while not frozen are ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_TIME = 7;
  localparam int NUM_ALM  = 3;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  localparam logic [3:0] ADDR_ALM0 = 4'h7;
  localparam logic [3:0] ADDR_CTRL = 4'hA;
  localparam logic [3:0] ADDR_STAT = 4'hB;
  localparam logic [3:0] ADDR_UIP  = 4'hC;

  typedef logic [NUM_TIME-1:0][7:0] time_t;
  typedef logic [NUM_ALM-1:0][7:0]  alarm_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int LEAD_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_tick_i,
  input  logic tb_tick_i,
  output logic uip_o,
  output logic adv_o,
  output logic xfer_o
);
  localparam int CW = $clog2(LEAD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LEAD_TICKS - 1);

  logic          uip_q, xfer_q;
  logic [CW-1:0] cnt_q;

  assign adv_o  = uip_q && !xfer_q && tb_tick_i && (cnt_q == LAST);
  assign uip_o  = uip_q;
  assign xfer_o = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q  <= 1'b0;
      xfer_q <= 1'b0;
      cnt_q  <= '0;
    end else if (xfer_q) begin
      uip_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else if (uip_q) begin
      if (tb_tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) xfer_q <= 1'b1;
      end
    end else if (sec_tick_i) begin
      uip_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  AST_XFER_IN_UIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> uip_o); // R2
  AST_UIP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !uip_o); // R2
  AST_IDLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uip_o && !sec_tick_i |=> !uip_o); // R12
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  time_t cur_i,
  output time_t nxt_o
);
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt_o  = cur_i;
    c_min  = (cur_i[IDX_SEC] == 8'h59);
    nxt_o[IDX_SEC] = c_min ? 8'h00 : bcd_inc(cur_i[IDX_SEC]);
    c_hour = c_min && (cur_i[IDX_MIN] == 8'h59);
    if (c_min) nxt_o[IDX_MIN] = (cur_i[IDX_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur_i[IDX_MIN]);
    c_day  = c_hour && (cur_i[IDX_HOUR] == 8'h23);
    if (c_hour) nxt_o[IDX_HOUR] = (cur_i[IDX_HOUR] == 8'h23) ? 8'h00 : bcd_inc(cur_i[IDX_HOUR]);
    if (c_day) nxt_o[IDX_DOW] = (cur_i[IDX_DOW] == 8'h07) ? 8'h01 : bcd_inc(cur_i[IDX_DOW]);
    c_mon  = c_day && (cur_i[IDX_DATE] == month_last(cur_i[IDX_MON], cur_i[IDX_YEAR]));
    if (c_day) nxt_o[IDX_DATE] = c_mon ? 8'h01 : bcd_inc(cur_i[IDX_DATE]);
    c_year = c_mon && (cur_i[IDX_MON] == 8'h12);
    if (c_mon) nxt_o[IDX_MON] = c_year ? 8'h01 : bcd_inc(cur_i[IDX_MON]);
    if (c_year) nxt_o[IDX_YEAR] = (cur_i[IDX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_i[IDX_YEAR]);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  time_t  time_i,
  input  alarm_t alm_i,
  output logic   hit_o
);
  logic [NUM_ALM-1:0] match;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_cmp
    assign match[i] = (alm_i[i][7:6] == 2'b11) || (alm_i[i] == time_i[i]);
  end

  assign hit_o = &match;
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_pkg::*;
#(
  parameter int LEAD_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       tb_tick_i,
  input  logic       per_evt_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       uip_o,
  output logic       irq_no
);
  localparam time_t RST_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  time_t      int_q, usr_q, int_d, usr_d, nxt;
  alarm_t     alm_q;
  logic [7:0] ctrl_q, rdata_q;
  logic       uf_q, af_q, pf_q;
  logic       adv, xfer, hit, stat_rd, wr_time, irq;
  logic       set_q;

  assign set_q   = ctrl_q[0];
  assign stat_rd = re_i && (addr_i == ADDR_STAT);
  assign wr_time = we_i && set_q && (addr_i < 4'd7);
  assign irq     = (uf_q && ctrl_q[1]) || (af_q && ctrl_q[2]) || (pf_q && ctrl_q[3]);
  assign irq_no  = ~irq;
  assign rdata_o = rdata_q;

  rtc_update_seq #(.LEAD_TICKS(LEAD_TICKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_tick_i(sec_tick_i), .tb_tick_i(tb_tick_i),
    .uip_o(uip_o), .adv_o(adv), .xfer_o(xfer)
  );

  rtc_time_adv u_adv (.cur_i(int_q), .nxt_o(nxt));

  rtc_alarm_cmp u_alm (.time_i(int_q), .alm_i(alm_q), .hit_o(hit));

  always_comb begin
    int_d = adv ? nxt : int_q;
    usr_d = usr_q;
    if (xfer && !set_q) usr_d = int_q;
    if (wr_time) begin
      int_d[addr_i[2:0]] = wdata_i;
      usr_d[addr_i[2:0]] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= RST_TIME;
      usr_q  <= RST_TIME;
      alm_q  <= '0;
      ctrl_q <= '0;
      uf_q   <= 1'b0;
      af_q   <= 1'b0;
      pf_q   <= 1'b0;
    end else begin
      int_q <= int_d;
      usr_q <= usr_d;
      if (we_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i;
      if (we_i && addr_i >= ADDR_ALM0 && addr_i < ADDR_CTRL)
        alm_q[addr_i - ADDR_ALM0] <= wdata_i;
      uf_q <= (uf_q && !stat_rd) || xfer;
      af_q <= (af_q && !stat_rd) || (xfer && hit);
      pf_q <= (pf_q && !stat_rd) || per_evt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      case (addr_i)
        4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: rdata_q <= usr_q[addr_i[2:0]];
        4'h7, 4'h8, 4'h9: rdata_q <= alm_q[addr_i - ADDR_ALM0];
        ADDR_CTRL:        rdata_q <= ctrl_q;
        ADDR_STAT:        rdata_q <= {irq, pf_q, af_q, uf_q, 4'h0};
        ADDR_UIP:         rdata_q <= {7'd0, uip_o};
        default:          rdata_q <= 8'h00;
      endcase
    end
  end

  AST_USR_CHANGE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(usr_q) |-> $past(xfer) || $past(we_i)); // R2
  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q && !we_i |=> $stable(usr_q)); // R3
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd && !xfer && !per_evt_i |=> !uf_q && !af_q && !pf_q); // R9
  AST_UF_EVERY_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> uf_q); // R7
endmodule

// File: tb/sim_rtc_update_ctrl.sv
module sim_rtc_update_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, tb_tick = 1'b0, per_evt = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       uip, irq_n;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic re_seen = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  rtc_update_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec_tick), .tb_tick_i(tb_tick),
    .per_evt_i(per_evt), .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .uip_o(uip), .irq_no(irq_n)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data
  always @(posedge clk) re_seen <= re;
  always @(negedge clk) begin
    if (re_seen && q_exp.size() > 0) chk(rdata, q_exp.pop_front(), q_tag.pop_front());
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    @(posedge clk); #2; re = 1'b1; addr = a;
    @(posedge clk); #2; re = 1'b0;
  endtask

  task automatic upd_start();
    @(posedge clk); #2; sec_tick = 1'b1;
    @(posedge clk); #2; sec_tick = 1'b0;
  endtask

  task automatic upd_end();
    @(posedge clk); #2; tb_tick = 1'b1;
    @(posedge clk); #2; tb_tick = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic second();
    upd_start();
    upd_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1
    chk({7'd0, uip}, 8'h00, "R1 uip");
    chk({7'd0, irq_n}, 8'h01, "R1 irq_no");
    rd(4'h0, 8'h00, "R1 sec");
    rd(4'h3, 8'h01, "R1 dow");
    rd(4'h4, 8'h01, "R1 date");
    rd(4'h5, 8'h01, "R1 month");
    rd(4'h6, 8'h00, "R1 year");
    rd(4'hB, 8'h00, "R1 status");

    // R4: frozen writes reach both copies
    wr(4'hA, 8'h01);
    wr(4'h7, 8'h30); wr(4'h8, 8'h30); wr(4'h9, 8'h30);
    wr(4'h0, 8'h58); wr(4'h1, 8'h59); wr(4'h2, 8'h23); wr(4'h3, 8'h07);
    wr(4'h4, 8'h28); wr(4'h5, 8'h02); wr(4'h6, 8'h23);
    rd(4'h0, 8'h58, "R4 sec written");
    rd(4'h4, 8'h28, "R4 date written");
    wr(4'hA, 8'h00);
    wr(4'h0, 8'h11);
    rd(4'h0, 8'h58, "R4 write ignored unfrozen");

    // R2: uip then transfer
    upd_start();
    chk({7'd0, uip}, 8'h01, "R2 uip raised");
    rd(4'hC, 8'h01, "R2 uip register");
    rd(4'h0, 8'h58, "R2 user held during uip");
    upd_end();
    chk({7'd0, uip}, 8'h00, "R2 uip cleared");
    rd(4'h0, 8'h59, "R2 sec transferred");
    rd(4'hB, 8'h10, "R7 uf flag");
    rd(4'hB, 8'h00, "R9 status cleared");
    chk({7'd0, irq_n}, 8'h01, "R10 uf not enabled");

    // R5 R6: non-leap Feb end rollover
    wr(4'hA, 8'h02);
    second();
    chk({7'd0, irq_n}, 8'h00, "R10 uf irq");
    rd(4'h0, 8'h00, "R5 sec wrap");
    rd(4'h1, 8'h00, "R5 min wrap");
    rd(4'h2, 8'h00, "R5 hour wrap");
    rd(4'h3, 8'h01, "R5 dow wrap");
    rd(4'h4, 8'h01, "R6 date after Feb 28 non-leap");
    rd(4'h5, 8'h03, "R6 month after Feb");
    rd(4'h6, 8'h23, "R5 year held");
    rd(4'hB, 8'h90, "R9 status with irq");
    chk({7'd0, irq_n}, 8'h01, "R9 irq after clear");

    // R3: freeze
    wr(4'hA, 8'h03);
    second();
    rd(4'h0, 8'h00, "R3 user frozen");
    rd(4'hB, 8'h90, "R7 uf while frozen");
    wr(4'hA, 8'h02);
    second();
    rd(4'h0, 8'h02, "R3 internal kept counting");

    // R6: leap February
    wr(4'hA, 8'h01);
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h23);
    wr(4'h4, 8'h28); wr(4'h5, 8'h02); wr(4'h6, 8'h24);
    wr(4'hA, 8'h00);
    second();
    rd(4'h4, 8'h29, "R6 leap Feb 29");
    rd(4'h5, 8'h02, "R6 leap month held");

    // R5: year wrap
    wr(4'hA, 8'h01);
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h23);
    wr(4'h4, 8'h31); wr(4'h5, 8'h12); wr(4'h6, 8'h99);
    wr(4'hA, 8'h00);
    second();
    rd(4'h4, 8'h01, "R5 date after Dec 31");
    rd(4'h5, 8'h01, "R5 month wrap");
    rd(4'h6, 8'h00, "R5 year wrap");

    // R8: alarm with don't-care bytes
    wr(4'hA, 8'h01);
    wr(4'h0, 8'h04);
    wr(4'h7, 8'h05); wr(4'h8, 8'hC0); wr(4'h9, 8'hFF);
    wr(4'hA, 8'h04);
    rd(4'hB, 8'h10, "R9 clear pending");
    second();
    chk({7'd0, irq_n}, 8'h00, "R8 alarm irq");
    rd(4'h0, 8'h05, "R8 sec at alarm");
    rd(4'hB, 8'hB0, "R8 alarm flag");
    second();
    rd(4'hB, 8'h10, "R8 no match");
    chk({7'd0, irq_n}, 8'h01, "R10 af cleared");

    // R11 periodic
    @(posedge clk); #2 per_evt = 1'b1;
    @(posedge clk); #2 per_evt = 1'b0;
    chk({7'd0, irq_n}, 8'h01, "R11 pf masked");
    rd(4'hB, 8'h40, "R11 pf flag");
    wr(4'hA, 8'h08);
    @(posedge clk); #2 per_evt = 1'b1;
    @(posedge clk); #2 per_evt = 1'b0;
    chk({7'd0, irq_n}, 8'h00, "R10 pf irq");
    rd(4'hB, 8'hC0, "R11 pf status");
    chk({7'd0, irq_n}, 8'h01, "R9 pf cleared");

    // R12 idle timebase ticks
    repeat (3) begin
      @(posedge clk); #2 tb_tick = 1'b1;
      @(posedge clk); #2 tb_tick = 1'b0;
    end
    chk({7'd0, uip}, 8'h00, "R12 uip idle");
    rd(4'h0, 8'h06, "R12 sec unchanged");
    rd(4'hB, 8'h00, "R12 no flag");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule